// File: doc/BRIEF.md
# Lane Write Mask and Data-Pin Drive Control

This block sits beside the array of a common-I/O synchronous memory whose word is four 8-bit bytes, each carrying one parity bit (36 bits in all). On every rising clock edge it samples the write controls and turns them into a registered per-lane write mask. It also registers the incoming write data so that data and mask reach the array in the same cycle. Finally it decides whether the bidirectional data pins may be driven.

Write qualification has two levels. A global write strobe claims every lane. Otherwise a byte-write strobe together with per-lane selects picks individual lanes. A lane's parity bit always travels with its data byte.

The pin drive follows an asynchronous active-low output enable. That enable is overridden in three cases: while the device is deselected, during a write cycle, and on the first cycle after the device becomes selected again.

Top module: `bytewrite_oe_ctl`

## Requirements
- R1: When the device is selected and `gwe_n` is low at a rising edge, `lane_we` is 4'hF after that edge, whatever `bwe_n` and `bsel_n` are.
- R2: When the device is selected, `gwe_n` is high and `bwe_n` is low at a rising edge, `lane_we[k]` after that edge equals the inverse of `bsel_n[k]`.
- R3: When the device is selected and both `gwe_n` and `bwe_n` are high at a rising edge, `lane_we` is 4'h0 after that edge. The cycle is a read.
- R4: `bit_we` expands the lane mask. Data bits `8k..8k+7` and parity bit `32+k` are enabled exactly when `lane_we[k]` is 1.
- R5: `wdata_q` holds the `wdata` value sampled at the same rising edge that produced the current `lane_we`.
- R6: When `sel` is low at a rising edge, `lane_we` is 4'h0 and `dq_oe` is 0 for the following cycle, whatever the other inputs are.
- R7: `dq_oe` is 0 whenever `oe_n` is high. A change on `oe_n` reaches `dq_oe` without waiting for a clock edge.
- R8: `dq_oe` is 0 in any cycle in which `lane_we` is nonzero, even with `oe_n` low.
- R9: In the first cycle after an edge that samples `sel` high following an edge that sampled it low, `dq_oe` is 0. In later selected read cycles, `dq_oe` equals the inverse of `oe_n`.
- R10: While `rst_n` is low, `lane_we`, `bit_we` and `wdata_q` are zero and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gwe_n | input | 1 | Global write strobe, active low, claims all lanes |
| bwe_n | input | 1 | Byte-write strobe, active low |
| bsel_n | input | 4 | Per-lane select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sel | input | 1 | Device selected status, 1 = selected |
| wdata | input | 36 | Write data, bytes in [31:0], parity k in bit 32+k |
| lane_we | output | 4 | Registered per-lane write mask |
| bit_we | output | 36 | Per-bit write enable, data plus paired parity |
| wdata_q | output | 36 | Registered write data aligned with the mask |
| dq_oe | output | 1 | Data-pin drive enable |

## Verification
`lane_we`, `bit_we` and `wdata_q` are due one rising edge after the controls are sampled. The bench therefore drives each stimulus on a falling edge and samples one time unit after the next rising edge. `dq_oe` has a combinational dependency on `oe_n`, so the R7 checks change `oe_n` mid-cycle and look a time unit later with no edge in between. The registered selection history makes the R9 override last exactly one cycle, so the check is made in the first cycle and again in the cycle after it.

// File: rtl/bytewrite_oe_ctl.sv
module bytewrite_oe_ctl #(
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              gwe_n,
  input  logic                              bwe_n,
  input  logic [LANES-1:0]                  bsel_n,
  input  logic                              oe_n,
  input  logic                              sel,
  input  logic [LANES*(LANE_BITS+1)-1:0]    wdata,
  output logic [LANES-1:0]                  lane_we,
  output logic [LANES*(LANE_BITS+1)-1:0]    bit_we,
  output logic [LANES*(LANE_BITS+1)-1:0]    wdata_q,
  output logic                              dq_oe
);
  localparam int DBITS = LANES * LANE_BITS;
  localparam int WORD  = LANES * (LANE_BITS + 1);

  logic [LANES-1:0] mask_d;
  logic             sel_q, sel_qq;

  assign mask_d = !sel   ? '0 :
                  !gwe_n ? '1 :
                  !bwe_n ? ~bsel_n : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_we <= '0;
      wdata_q <= '0;
      sel_q   <= 1'b0;
      sel_qq  <= 1'b0;
    end else begin
      lane_we <= mask_d;
      wdata_q <= wdata;
      sel_q   <= sel;
      sel_qq  <= sel_q;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign bit_we[k*LANE_BITS +: LANE_BITS] = {LANE_BITS{lane_we[k]}};
    assign bit_we[DBITS + k]                = lane_we[k];
  end

  // drive only when selected, reading, past the re-select cycle, and enabled
  assign dq_oe = !oe_n && sel_q && sel_qq && (lane_we == '0);

  p_global_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !gwe_n) |=> (lane_we == {LANES{1'b1}}));
  p_byte_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && gwe_n && !bwe_n) |=> (lane_we == ~$past(bsel_n)));
  p_idle_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && gwe_n && bwe_n) |=> (lane_we == '0));
  p_data_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wdata_q == $past(wdata)));
  p_desel_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (lane_we == '0 && !dq_oe));
  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
  p_write_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> !dq_oe);
  p_reselect_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel ##1 sel) |=> !dq_oe);
  p_word_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bit_we) == $countones(lane_we) * (LANE_BITS + 1));

  initial assert (WORD == DBITS + LANES);
endmodule

// File: tb/tb_bytewrite_oe_ctl.sv
module tb_bytewrite_oe_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gwe_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1, sel = 1'b0;
  logic [3:0]  bsel_n = 4'hF;
  logic [35:0] wdata = '0;
  logic [3:0]  lane_we;
  logic [35:0] bit_we, wdata_q;
  logic        dq_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bytewrite_oe_ctl dut (.clk, .rst_n, .gwe_n, .bwe_n, .bsel_n, .oe_n, .sel,
                        .wdata, .lane_we, .bit_we, .wdata_q, .dq_oe);

  // {gwe_n, bwe_n, bsel_n[3:0], oe_n, exp_we[3:0], exp_oe}
  localparam int N = 10;
  localparam logic [11:0] VEC [N] = '{
    {1'b0, 1'b1, 4'hF, 1'b0, 4'hF, 1'b0},
    {1'b0, 1'b0, 4'h5, 1'b0, 4'hF, 1'b0},
    {1'b1, 1'b0, 4'hE, 1'b0, 4'h1, 1'b0},
    {1'b1, 1'b0, 4'h5, 1'b0, 4'hA, 1'b0},
    {1'b1, 1'b0, 4'h0, 1'b0, 4'hF, 1'b0},
    {1'b1, 1'b0, 4'hF, 1'b0, 4'h0, 1'b1},
    {1'b1, 1'b1, 4'h0, 1'b0, 4'h0, 1'b1},
    {1'b1, 1'b1, 4'h3, 1'b1, 4'h0, 1'b0},
    {1'b1, 1'b0, 4'h7, 1'b0, 4'h8, 1'b0},
    {1'b0, 1'b1, 4'h0, 1'b1, 4'hF, 1'b0}
  };

  function automatic logic [35:0] expand(input logic [3:0] m);
    logic [35:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 8; b++) r[k*8+b] = m[k];
      r[32+k] = m[k];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic g, input logic b, input logic [3:0] s,
                       input logic o, input logic sl, input logic [35:0] d);
    @(negedge clk);
    gwe_n = g; bwe_n = b; bsel_n = s; oe_n = o; sel = sl; wdata = d;
    @(posedge clk); #1;
  endtask

  initial begin
    #1;
    chk("R10 reset lane_we", {32'd0, lane_we}, 36'd0);
    chk("R10 reset dq_oe", {35'd0, dq_oe}, 36'd0);
    chk("R10 reset wdata_q", wdata_q, 36'd0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // get selected and past the re-select cycle
    drive(1'b1, 1'b1, 4'hF, 1'b0, 1'b1, '0);
    drive(1'b1, 1'b1, 4'hF, 1'b0, 1'b1, '0);
    chk("R9 steady read drives", {35'd0, dq_oe}, 36'd1);

    for (int i = 0; i < N; i++) begin
      logic [11:0] v = VEC[i];
      logic [35:0] d = {4'(i), 32'hA5C3_0000 | 32'(i * 37)};
      drive(v[11], v[10], v[9:6], v[5], 1'b1, d);
      chk($sformatf("R1/R2/R3 row %0d lane_we", i), {32'd0, lane_we}, {32'd0, v[4:1]});
      chk($sformatf("R4 row %0d bit_we", i), bit_we, expand(v[4:1]));
      chk($sformatf("R5 row %0d wdata_q", i), wdata_q, d);
      chk($sformatf("R7/R8 row %0d dq_oe", i), {35'd0, dq_oe}, {35'd0, v[0]});
    end

    // R7: asynchronous oe_n during a selected read
    drive(1'b1, 1'b1, 4'hF, 1'b0, 1'b1, '0);
    chk("R7 read drives", {35'd0, dq_oe}, 36'd1);
    oe_n = 1'b1; #1;
    chk("R7 async release", {35'd0, dq_oe}, 36'd0);
    oe_n = 1'b0; #1;
    chk("R7 async reassert", {35'd0, dq_oe}, 36'd1);

    // R6: deselected edge with a global write requested
    drive(1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 36'hF_FFFF_FFFF);
    chk("R6 deselect lane_we", {32'd0, lane_we}, 36'd0);
    chk("R6 deselect dq_oe", {35'd0, dq_oe}, 36'd0);
    // R9: first selected read after deselect stays off, next one drives
    drive(1'b1, 1'b1, 4'hF, 1'b0, 1'b1, '0);
    chk("R9 first cycle forced off", {35'd0, dq_oe}, 36'd0);
    drive(1'b1, 1'b1, 4'hF, 1'b0, 1'b1, '0);
    chk("R9 second cycle drives", {35'd0, dq_oe}, 36'd1);

    // R10: reset mid-run after a write
    drive(1'b0, 1'b1, 4'hF, 1'b0, 1'b1, 36'h1_2345_6789);
    chk("R1 before reset", {32'd0, lane_we}, 36'hF);
    rst_n = 1'b0; #1;
    chk("R10 mid reset lane_we", {32'd0, lane_we}, 36'd0);
    chk("R10 mid reset bit_we", bit_we, 36'd0);
    chk("R10 mid reset wdata_q", wdata_q, 36'd0);
    chk("R10 mid reset dq_oe", {35'd0, dq_oe}, 36'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule